// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave has left stuck, typically holding SDA low after a transfer was cut short. When asked to recover, it first checks the controller status. If the bus is neither active nor holding unsent write data, it reports success at once. Otherwise it takes the SCL and SDA pins away from the normal controller through a pin-select output. It then drains the controller: a last-byte write followed by a read when the read buffer is full, or a last-byte write of 0xFF when the controller still owns the bus. After the drain it clocks out up to nine open-drain pulses.

Each pulse pulls SCL low, then SDA low, then lets SCL float. If a slave is still stretching SCL, the block waits in two escalating steps and then records the SCL level. It ends the pulse by letting SDA float. The loop stops early once SDA reads high and SCL was seen high at the end of the previous pulse. The pins then go back to the controller. After a settling wait, the bus-active flag decides between success and a not-ready error.

All delays come from a single down-counter scaled by a cycles-per-microsecond parameter. The block only ever pulls a line low; it never drives it high.

States:
- `ST_IDLE`: waits for a start request.
- `ST_MUX_ON`: takes the pins.
- `ST_DRAIN_WR`: issues the last-byte write.
- `ST_DRAIN_RD`: issues the read.
- `ST_TEST`: evaluates the loop exit.
- `ST_SCL_LOW`: holds SCL low.
- `ST_SDA_LOW`: holds SCL and SDA low.
- `ST_SCL_FREE`: lets SCL float.
- `ST_WAIT_SHORT`: first wait on a stretched SCL.
- `ST_WAIT_LONG`: second, longer wait on a stretched SCL.
- `ST_SDA_FREE`: lets SDA float.
- `ST_SETTLE`: pins are returned; waits before sampling.
- `ST_DONE`: reports the result.

Transitions:
- Idle goes to done when the bus is already quiet, and to mux-on otherwise.
- Mux-on goes to drain-write when a drain is needed, and to test otherwise.
- Drain-write goes to drain-read when the read buffer was full, and to test otherwise.
- Test goes to settle on exit, and to SCL-low otherwise.
- The pulse states run in order.
- SCL-free and wait-short branch to SDA-free when SCL reads high, and to the next wait when it reads low.
- Wait-long goes to SDA-free.
- SDA-free goes back to test.
- Settle goes to done, and done goes to idle.

Top module: `i2c_bus_clear`

## Requirements
- R1: A start with both `bus_active_i` and `wr_full_i` low produces `done_o` in the cycle after the start. No pull, mux or flush output is asserted, `pulses_o` reads 0 and `error_o` reads 0.
- R2: `pin_sel_o` (1 = pins owned by recovery) rises in the cycle after an accepted start and stays high through the pulse loop. It falls for the whole settle wait and for done.
- R3: Drain order after mux-on. With the read buffer full, the block gives one cycle of `flush_wr_o` with `flush_data_o` = 0x00, then one cycle of `flush_rd_o`. With the read buffer not full and bus master set, it gives one cycle of `flush_wr_o` with data 0xFF. With neither, it gives no strobe.
- R4: Each pulse holds SCL pulled for 5 µs, then both lines pulled for 5 µs, then SDA only pulled for 5 µs while SCL floats.
- R5: If SCL reads low at the end of the float window, SDA stays pulled for a further 20 µs. If SCL is still low after that, it stays pulled for a further `LONG_US` µs. The SCL level at the end of the last wait taken is recorded.
- R6: Each pulse ends with both lines released for 5 µs.
- R7: At most `MAX_PULSES` (9) pulses are made. Before each pulse the loop exits if SDA reads high and SCL was recorded high at the end of the previous pulse, so at least one pulse is always made.
- R8: After the pins return, the block waits 10 µs. `error_o` then equals the sampled `bus_active_i`.
- R9: `done_o` is high for exactly one cycle. `pulses_o` then equals the number of completed pulses.
- R10: A start request while a sequence is running has no effect on any output.
- R11: The pull enables are asserted only while `pin_sel_o` is high, and SDA is first pulled only while SCL is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery request, sampled in idle |
| bus_active_i | input | 1 | Controller reports the bus busy |
| wr_full_i | input | 1 | Controller write buffer holds data |
| rd_full_i | input | 1 | Controller read buffer holds data |
| bus_master_i | input | 1 | Controller still owns the bus |
| scl_i | input | 1 | Sampled SCL level (asynchronous) |
| sda_i | input | 1 | Sampled SDA level (asynchronous) |
| scl_pull_o | output | 1 | Pull SCL low |
| sda_pull_o | output | 1 | Pull SDA low |
| pin_sel_o | output | 1 | 1 = pins owned by recovery, 0 = controller |
| flush_wr_o | output | 1 | One-cycle last-byte write strobe |
| flush_data_o | output | 8 | Data accompanying the write strobe |
| flush_rd_o | output | 1 | One-cycle read strobe |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Bus still active at the end (valid with done) |
| pulses_o | output | 4 | Completed pulse count (valid with done) |

## Verification
The bench models a slave that releases SDA after a set number of pulses, and stretches SCL for a set time after each release.

It drives four stretch regimes:
- no stretch;
- stretch released inside the short wait;
- stretch released inside the long wait;
- a permanently stuck SCL.

A design that skipped the escalation, or mistimed it, would shift every later pin edge and the cycle of `done_o`. A design that recorded the SCL level at the wrong point would stop early with a stuck SCL, or run all nine pulses when it should exit.

The SDA-already-high case checks that the first pulse is never skipped, and a permanently held SDA checks the nine-pulse limit. Each drain variant checks strobe order and data. A start injected mid-run would, in a faulty design, restart the sequence and break the per-cycle comparison.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MUX_ON,
        ST_DRAIN_WR,
        ST_DRAIN_RD,
        ST_TEST,
        ST_SCL_LOW,
        ST_SDA_LOW,
        ST_SCL_FREE,
        ST_WAIT_SHORT,
        ST_WAIT_LONG,
        ST_SDA_FREE,
        ST_SETTLE,
        ST_DONE
    } bc_state_e;

endpackage

// File: rtl/i2c_bc_sync.sv
module i2c_bc_sync #(
    parameter int              WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic stable_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= RST_VAL[g];
                stable_q <= RST_VAL[g];
            end else begin
                meta_q   <= d_i[g];
                stable_q <= meta_q;
            end
        end
        assign q_o[g] = stable_q;
    end

endmodule

// File: rtl/i2c_bc_timer.sv
module i2c_bc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (load_i)
            count_q <= load_val_i;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign expired_o = (count_q == '0);

    // a freshly loaded count never reads expired in the next cycle unless zero was loaded
    p_load_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !expired_o);

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
    import i2c_bc_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int PULSE_US   = 5,
    parameter int SHORT_US   = 20,
    parameter int LONG_US    = 10000,
    parameter int SETTLE_US  = 10,
    parameter int MAX_PULSES = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic                              bus_active_i,
    input  logic                              wr_full_i,
    input  logic                              rd_full_i,
    input  logic                              bus_master_i,
    input  logic                              scl_i,
    input  logic                              sda_i,
    output logic                              scl_pull_o,
    output logic                              sda_pull_o,
    output logic                              pin_sel_o,
    output logic                              flush_wr_o,
    output logic [7:0]                        flush_data_o,
    output logic                              flush_rd_o,
    output logic                              done_o,
    output logic                              error_o,
    output logic [$clog2(MAX_PULSES+1)-1:0]   pulses_o
);

    localparam int IW      = $clog2(MAX_PULSES + 1);
    localparam int MAX_CYC = LONG_US * CYC_PER_US;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_US  * CYC_PER_US - 1);
    localparam logic [CNT_W-1:0] LD_SHORT  = CNT_W'(SHORT_US  * CYC_PER_US - 1);
    localparam logic [CNT_W-1:0] LD_LONG   = CNT_W'(LONG_US   * CYC_PER_US - 1);
    localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_US * CYC_PER_US - 1);
    localparam logic [IW-1:0]    ITER_MAX  = IW'(MAX_PULSES);

    bc_state_e        state_q, state_d;
    logic [IW-1:0]    iter_q;
    logic             seen_q;
    logic             rd_q, mst_q, err_q;
    logic             scl_s, sda_s;
    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;

    i2c_bc_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    i2c_bc_timer #(.W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = (bus_active_i || wr_full_i) ? ST_MUX_ON : ST_DONE;
            ST_MUX_ON:     state_d = (rd_q || mst_q) ? ST_DRAIN_WR : ST_TEST;
            ST_DRAIN_WR:   state_d = rd_q ? ST_DRAIN_RD : ST_TEST;
            ST_DRAIN_RD:   state_d = ST_TEST;
            ST_TEST:       state_d = (iter_q == ITER_MAX || (sda_s && seen_q)) ? ST_SETTLE : ST_SCL_LOW;
            ST_SCL_LOW:    if (tmr_exp) state_d = ST_SDA_LOW;
            ST_SDA_LOW:    if (tmr_exp) state_d = ST_SCL_FREE;
            ST_SCL_FREE:   if (tmr_exp) state_d = scl_s ? ST_SDA_FREE : ST_WAIT_SHORT;
            ST_WAIT_SHORT: if (tmr_exp) state_d = scl_s ? ST_SDA_FREE : ST_WAIT_LONG;
            ST_WAIT_LONG:  if (tmr_exp) state_d = ST_SDA_FREE;
            ST_SDA_FREE:   if (tmr_exp) state_d = ST_TEST;
            ST_SETTLE:     if (tmr_exp) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // timer loads on entry to every timed state
    always_comb begin
        unique case (state_d)
            ST_WAIT_SHORT: tmr_val = LD_SHORT;
            ST_WAIT_LONG:  tmr_val = LD_LONG;
            ST_SETTLE:     tmr_val = LD_SETTLE;
            default:       tmr_val = LD_PULSE;
        endcase
        tmr_load = (state_d != state_q) &&
                   (state_d inside {ST_SCL_LOW, ST_SDA_LOW, ST_SCL_FREE, ST_WAIT_SHORT,
                                    ST_WAIT_LONG, ST_SDA_FREE, ST_SETTLE});
    end

    // state register and per-run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            seen_q  <= 1'b0;
            rd_q    <= 1'b0;
            mst_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                iter_q <= '0;
                seen_q <= 1'b0;
                rd_q   <= rd_full_i;
                mst_q  <= bus_master_i;
                err_q  <= 1'b0;
            end
            if (state_d == ST_SDA_FREE && state_q != ST_SDA_FREE)
                seen_q <= scl_s;
            if (state_q == ST_SDA_FREE && tmr_exp)
                iter_q <= iter_q + 1'b1;
            if (state_q == ST_SETTLE && tmr_exp)
                err_q <= bus_active_i;
        end
    end

    // outputs decoded from state
    always_comb begin
        scl_pull_o   = 1'b0;
        sda_pull_o   = 1'b0;
        pin_sel_o    = 1'b0;
        flush_wr_o   = 1'b0;
        flush_rd_o   = 1'b0;
        flush_data_o = 8'h00;
        done_o       = 1'b0;
        unique case (state_q)
            ST_MUX_ON, ST_TEST, ST_SDA_FREE: pin_sel_o = 1'b1;
            ST_DRAIN_WR: begin
                pin_sel_o    = 1'b1;
                flush_wr_o   = 1'b1;
                flush_data_o = rd_q ? 8'h00 : 8'hFF;
            end
            ST_DRAIN_RD: begin
                pin_sel_o  = 1'b1;
                flush_rd_o = 1'b1;
            end
            ST_SCL_LOW: begin
                pin_sel_o  = 1'b1;
                scl_pull_o = 1'b1;
            end
            ST_SDA_LOW: begin
                pin_sel_o  = 1'b1;
                scl_pull_o = 1'b1;
                sda_pull_o = 1'b1;
            end
            ST_SCL_FREE, ST_WAIT_SHORT, ST_WAIT_LONG: begin
                pin_sel_o  = 1'b1;
                sda_pull_o = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign error_o  = err_q;
    assign pulses_o = iter_q;

    p_pull_needs_mux_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_o || sda_pull_o) |-> pin_sel_o);
    p_sda_after_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> scl_pull_o);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_pulse_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pulses_o <= ITER_MAX));
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_wr_o, flush_rd_o}));
    p_read_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_rd_o |-> $past(flush_wr_o));
    p_mux_off_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pin_sel_o);
    p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel_o && start_i) |=> (state_q != ST_IDLE));

endmodule

// File: tb/i2c_bus_clear_test.sv
module i2c_bus_clear_test;

    localparam int CPU  = 2;
    localparam int LONG = 100;
    localparam int NP   = 5 * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, ba = 1'b0, wf = 1'b0, rf = 1'b0, ms = 1'b0;
    logic scl_pull, sda_pull, pin_sel, fwr, frd, done, err;
    logic [7:0] fdata;
    logic [3:0] pulses;
    logic scl_line, sda_line;

    int vectors = 0, fails = 0;
    int stretch_len = 0, hold_pulses = 0;
    int str_cnt = 0, pulses_seen = 0;
    logic prev_oe = 1'b0, clr_p = 1'b0, cmp_en = 1'b0;
    string ctag = "reset";

    logic e_mux = 0, e_scl = 0, e_sda = 0, e_wr = 0, e_rd = 0, e_done = 0;
    logic [7:0] e_data = 0;
    int e_cnt = 0, e_err = 0;

    always #2 clk = ~clk;

    i2c_bus_clear #(.CYC_PER_US(CPU), .LONG_US(LONG)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .bus_active_i(ba),
        .wr_full_i(wf), .rd_full_i(rf), .bus_master_i(ms),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .pin_sel_o(pin_sel),
        .flush_wr_o(fwr), .flush_data_o(fdata), .flush_rd_o(frd),
        .done_o(done), .error_o(err), .pulses_o(pulses)
    );

    // slave model: stretches SCL after release, holds SDA for a number of pulses
    always @(posedge clk) begin
        if (scl_pull) str_cnt <= 0;
        else if (str_cnt < 10000000) str_cnt <= str_cnt + 1;
        prev_oe <= scl_pull;
        if (clr_p) pulses_seen <= 0;
        else if (scl_pull && !prev_oe) pulses_seen <= pulses_seen + 1;
    end
    assign scl_line = !scl_pull && (str_cnt >= stretch_len);
    assign sda_line = !sda_pull && (pulses_seen >= hold_pulses);

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, ctag, $time, act, exp);
        end
    endtask

    always @(negedge clk) if (cmp_en) begin
        chk("R2 pin_sel", pin_sel, e_mux);
        chk("R4 scl_pull", scl_pull, e_scl);
        chk("R6 sda_pull", sda_pull, e_sda);
        chk("R3 flush_wr", fwr, e_wr);
        chk("R3 flush_rd", frd, e_rd);
        chk("R9 done", done, e_done);
        if (e_wr) chk("R3 flush_data", fdata, e_data);
        if (e_done) begin
            chk("R7 pulses", pulses, e_cnt);
            chk("R8 error", err, e_err);
        end
    end

    task automatic ph(logic m, logic s, logic d, logic w, logic r, logic dn, int n);
        e_mux = m; e_scl = s; e_sda = d; e_wr = w; e_rd = r; e_done = dn;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic run_case(string tag, logic a, logic w, logic r, logic m,
                            int h, int l, bit poke);
        int path;
        bit seen;
        int i;
        @(negedge clk);
        ctag = tag; ba = a; wf = w; rf = r; ms = m;
        hold_pulses = h; stretch_len = l; clr_p = 1'b1;
        @(negedge clk);
        clr_p = 1'b0; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        if (poke) fork
            begin repeat (40) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; end
        join_none
        path = (l <= 5) ? 0 : (l <= 45) ? 1 : (l <= 245) ? 2 : 3;
        if (!(a || w)) begin
            e_cnt = 0; e_err = 0;
            ph(0, 0, 0, 0, 0, 1, 1);            // R1 immediate success
        end else begin
            ph(1, 0, 0, 0, 0, 0, 1);            // mux on
            if (r) begin
                e_data = 8'h00; ph(1, 0, 0, 1, 0, 0, 1);
                ph(1, 0, 0, 0, 1, 0, 1);
            end else if (m) begin
                e_data = 8'hFF; ph(1, 0, 0, 1, 0, 0, 1);
            end
            seen = 0;
            i = 0;
            forever begin
                ph(1, 0, 0, 0, 0, 0, 1);        // loop test
                if (i == 9 || (seen && pulses_seen >= h)) break;
                ph(1, 1, 0, 0, 0, 0, NP);
                ph(1, 1, 1, 0, 0, 0, NP);
                ph(1, 0, 1, 0, 0, 0, NP);
                if (path >= 1) ph(1, 0, 1, 0, 0, 0, 20 * CPU);   // R5 short wait
                if (path >= 2) ph(1, 0, 1, 0, 0, 0, LONG * CPU); // R5 long wait
                ph(1, 0, 0, 0, 0, 0, NP);
                seen = (path != 3);
                i++;
            end
            e_cnt = i; e_err = a;
            ph(0, 0, 0, 0, 0, 0, 10 * CPU);     // settle
            ph(0, 0, 0, 0, 0, 1, 1);
        end
        ph(0, 0, 0, 0, 0, 0, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; cmp_en = 1'b1;                       // reset state checked as idle outputs
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        run_case("R1 quiet bus",              0, 0, 0, 0, 0, 0,      0);
        run_case("R4 R7 no drain sda free@3", 0, 1, 0, 0, 3, 0,      0);
        run_case("R3 read drain first pulse", 0, 1, 1, 1, 0, 0,      0);
        run_case("R3 R10 master short str",   1, 0, 0, 1, 2, 30,     1);
        run_case("R5 long stretch err R8",    1, 1, 0, 0, 5, 100,    0);
        run_case("R5 R7 stuck scl",           0, 1, 0, 0, 0, 100000, 0);
        run_case("R7 stuck sda",              1, 1, 1, 0, 20, 0,     0);
        cmp_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog [%s] actual=running expected=finished", ctag);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule